// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This unit sits beside the execute stage of a five-stage in-order pipeline. Each stage lasts a fixed number of clock cycles, two by default. At each stage boundary the unit compares the source register indices of the instruction moving into execute with the destination of the instruction already there. From that comparison it decides the operand selects, bubbles, replay requests and write kills for the stage that follows.

When the older instruction is an ALU operation, the unit selects a bypass of the ALU's own previous result, and the pipeline does not stall. When the older instruction is a load, the dependent instruction cannot be served in time. The unit then turns the next two execute slots into no-ops and asks the front end to fetch the dependent instruction again.

A conditional branch that resolves taken in execute lets the two instructions behind it keep flowing down the pipeline. The memory write and register write of those two instructions are disabled. The unit marks each slot as it reaches the memory stage and the writeback stage. A not-taken branch costs nothing.

Top module: `hazard_fwd_unit`

## Requirements
- R1: While rst_n is low and in the first cycle after it rises, every output is 0.
- R2: stage_end is high on the last cycle of every STAGE_CYC-cycle stage, first in cycle STAGE_CYC-1 after reset release. All other outputs change only on the clock edge at which stage_end is high, and hold for the whole next stage.
- R3: An instruction enters execute as a live instruction when id_valid is high and no squash or bubble applies. If the live instruction already in execute writes a register (we=1), is not a load, and has a destination that is not 0, then for the next stage fwd_a is high if id_rs1 equals that destination, and fwd_b is high if id_rs2 equals it. The two selects are independent.
- R4: No forwarding and no bubble are produced when the older destination is register 0, when the older instruction has we=0, or when the older slot is empty.
- R5: If the older live instruction is a load and either source matches as in R3, then bubble is high for the next two stages, replay is high for the first of them only, and fwd_a and fwd_b stay low.
- R6: Bubble slots never cause forwarding or a further bubble. The instruction replayed right after the two bubbles executes without a bubble.
- R7: If ex_br_taken is high at a boundary while execute holds a live instruction, the next two slots entering execute are squashed. Each squashed slot raises kill_mem in the stage after it leaves execute and kill_wb in the stage after that.
- R8: With ex_br_taken low, no slot is squashed.
- R9: Squashed slots never cause forwarding or a bubble for the slot behind them. ex_br_taken is ignored while execute holds a squashed, bubble or empty slot.
- R10: Bubble slots also raise kill_mem and then kill_wb, with the same timing as in R7.
- R11: A squash takes priority over a load-use match on the same slot, so that slot becomes squashed and not a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_valid | input | 1 | An instruction is moving into execute |
| id_rs1 | input | REG_AW | First source index of that instruction |
| id_rs2 | input | REG_AW | Second source index of that instruction |
| id_rd | input | REG_AW | Destination index of that instruction |
| id_we | input | 1 | That instruction writes a register |
| id_load | input | 1 | That instruction is a load |
| ex_br_taken | input | 1 | The instruction in execute is a branch resolved taken |
| stage_end | output | 1 | Last cycle of the current stage |
| fwd_a | output | 1 | First operand takes the previous ALU result |
| fwd_b | output | 1 | Second operand takes the previous ALU result |
| bubble | output | 1 | Execute holds an injected no-op |
| replay | output | 1 | Front end must refetch the dependent instruction |
| kill_mem | output | 1 | Disable the data write of the instruction in memory |
| kill_wb | output | 1 | Disable the register write of the instruction in writeback |

## Verification
Inputs are sampled on the stage_end edge. fwd_a, fwd_b, bubble and replay are due in the first cycle of the next stage. kill_mem is due one stage after the slot's execute stage, and kill_wb two stages after it. The bench holds each input set for a whole stage and advances its reference model exactly once, on the cycle where stage_end is expected. It compares every output at the falling edge of every cycle, so a result that arrives a stage early or late, or changes in the middle of a stage, is caught.

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int REG_AW    = 5,
  parameter int STAGE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic [REG_AW-1:0] id_rd,
  input  logic              id_we,
  input  logic              id_load,
  input  logic              ex_br_taken,
  output logic              stage_end,
  output logic              fwd_a,
  output logic              fwd_b,
  output logic              bubble,
  output logic              replay,
  output logic              kill_mem,
  output logic              kill_wb
);

  localparam int PH_W = (STAGE_CYC > 2) ? $clog2(STAGE_CYC) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STAGE_CYC - 1);

  typedef enum logic [1:0] {SL_EMPTY, SL_LIVE, SL_SQUASH, SL_BUBBLE} slot_t;

  logic [PH_W-1:0]   ph;
  slot_t             ex_kind, nx_kind;
  logic [REG_AW-1:0] ex_rd;
  logic              ex_we, ex_ld;
  logic              sq_left, bub_left;
  logic              prev_wr, hit_a, hit_b, br_take, squash_in, load_use;

  assign stage_end = (ph == PH_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)         ph <= '0;
    else if (stage_end) ph <= '0;
    else                ph <= ph + 1'b1;
  end

  assign prev_wr   = (ex_kind == SL_LIVE) && ex_we && (ex_rd != '0);
  assign hit_a     = id_valid && prev_wr && (id_rs1 == ex_rd);
  assign hit_b     = id_valid && prev_wr && (id_rs2 == ex_rd);
  assign br_take   = ex_br_taken && (ex_kind == SL_LIVE);
  assign squash_in = br_take || sq_left;
  assign load_use  = !squash_in && !bub_left && ex_ld && (hit_a || hit_b);

  always_comb begin
    if (squash_in)                 nx_kind = SL_SQUASH;
    else if (bub_left || load_use) nx_kind = SL_BUBBLE;
    else if (id_valid)             nx_kind = SL_LIVE;
    else                           nx_kind = SL_EMPTY;
  end

  assign bubble = (ex_kind == SL_BUBBLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ex_kind  <= SL_EMPTY;
      ex_rd    <= '0;
      ex_we    <= 1'b0;
      ex_ld    <= 1'b0;
      sq_left  <= 1'b0;
      bub_left <= 1'b0;
      replay   <= 1'b0;
      fwd_a    <= 1'b0;
      fwd_b    <= 1'b0;
      kill_mem <= 1'b0;
      kill_wb  <= 1'b0;
    end else if (stage_end) begin
      ex_kind  <= nx_kind;
      ex_rd    <= id_rd;
      ex_we    <= id_we;
      ex_ld    <= id_load;
      sq_left  <= br_take;
      bub_left <= load_use;
      replay   <= load_use;
      fwd_a    <= (nx_kind == SL_LIVE) && hit_a && !ex_ld;
      fwd_b    <= (nx_kind == SL_LIVE) && hit_b && !ex_ld;
      kill_mem <= (ex_kind == SL_SQUASH) || (ex_kind == SL_BUBBLE);
      kill_wb  <= kill_mem;
    end
  end

endmodule

// File: rtl/hazard_fwd_unit_chk.sv
module hazard_fwd_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic stage_end,
  input logic fwd_a,
  input logic fwd_b,
  input logic bubble,
  input logic replay,
  input logic kill_mem,
  input logic kill_wb
);

  assert_hold_midstage_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_end |=> $stable({fwd_a, fwd_b, bubble, replay, kill_mem, kill_wb}));

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stage_end |=> !stage_end);

  assert_no_fwd_in_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |-> !(fwd_a || fwd_b));

  assert_replay_has_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> bubble);

  assert_second_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_end && replay) |=> (bubble && !replay));

  assert_no_third_bubble_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_end && bubble && !replay) |=> !bubble);

  assert_bubble_killed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_end && bubble) |=> kill_mem);

  assert_kill_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stage_end |=> (kill_wb == $past(kill_mem)));

endmodule

bind hazard_fwd_unit hazard_fwd_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stage_end(stage_end), .fwd_a(fwd_a), .fwd_b(fwd_b),
  .bubble(bubble), .replay(replay), .kill_mem(kill_mem), .kill_wb(kill_wb)
);

// File: tb/sim_hazard_fwd_unit.sv
`timescale 1ns/1ps
module sim_hazard_fwd_unit;
  localparam int AW = 5;
  localparam int S  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic id_valid = 0, id_we = 0, id_load = 0, ex_br_taken = 0;
  logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, id_rd = '0;
  logic stage_end, fwd_a, fwd_b, bubble, replay, kill_mem, kill_wb;

  hazard_fwd_unit #(.REG_AW(AW), .STAGE_CYC(S)) u0 (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_rd(id_rd), .id_we(id_we), .id_load(id_load), .ex_br_taken(ex_br_taken),
    .stage_end(stage_end), .fwd_a(fwd_a), .fwd_b(fwd_b), .bubble(bubble),
    .replay(replay), .kill_mem(kill_mem), .kill_wb(kill_wb));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R1";

  // slot kinds: 0 empty, 1 live, 2 squashed, 3 bubble; index 0 = execute
  int kinds[$];
  int m_rd, m_we, m_ld, m_sq, m_bub;
  bit e_fa, e_fb, e_rep;

  function automatic bit dead(int k);
    return (k == 2) || (k == 3);
  endfunction

  task automatic compare(input bit tick_exp);
    logic [6:0] act, exp;
    act = {stage_end, fwd_a, fwd_b, bubble, replay, kill_mem, kill_wb};
    exp = {tick_exp, e_fa, e_fb, kinds[0] == 3, e_rep, dead(kinds[1]), dead(kinds[2])};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (R2 for stage_end bit 6) at %0t: actual %b expected %b",
               cur_req, $time, act, exp);
    end
  endtask

  task automatic model_step(input int rs1, input int rs2, input int rd,
                            input bit we, input bit ld, input bit vld, input bit br);
    int nk;
    bit h1, h2, take;
    take = br && kinds[0] == 1;
    h1 = vld && kinds[0] == 1 && m_we != 0 && m_rd != 0 && rs1 == m_rd;
    h2 = vld && kinds[0] == 1 && m_we != 0 && m_rd != 0 && rs2 == m_rd;
    e_fa = 0; e_fb = 0; e_rep = 0;
    if (take || m_sq > 0) begin
      nk = 2;
      m_sq = take ? 1 : m_sq - 1;
    end else if (m_bub > 0) begin
      nk = 3; m_bub--;
    end else if (vld && m_ld != 0 && (h1 || h2)) begin
      nk = 3; m_bub = 1; e_rep = 1;
    end else if (vld) begin
      nk = 1; e_fa = h1; e_fb = h2;
    end else nk = 0;
    kinds.push_front(nk);
    void'(kinds.pop_back());
    m_rd = rd; m_we = we; m_ld = ld;
  endtask

  task automatic stage(input int rs1, input int rs2, input int rd,
                       input bit we, input bit ld, input bit vld, input bit br);
    for (int c = 0; c < S; c++) begin
      compare(c == S - 1);
      if (c == 0) begin
        id_rs1 = AW'(rs1); id_rs2 = AW'(rs2); id_rd = AW'(rd);
        id_we = we; id_load = ld; id_valid = vld; ex_br_taken = br;
      end
      if (c == S - 1) model_step(rs1, rs2, rd, we, ld, vld, br);
      @(negedge clk);
    end
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    kinds = '{0, 0, 0};
    m_rd = 0; m_we = 0; m_ld = 0; m_sq = 0; m_bub = 0;
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    checks++;
    if ({stage_end, fwd_a, fwd_b, bubble, replay, kill_mem, kill_wb} !== 7'b0) begin
      errors++;
      $display("FAIL R1 reset: actual %b expected 0000000",
               {stage_end, fwd_a, fwd_b, bubble, replay, kill_mem, kill_wb});
    end
    rst_n = 1'b1;

    cur_req = "R1";
    stage(0, 0, 0, 0, 0, 0, 0);
    // R3: forwarding on each operand and both
    cur_req = "R3";
    stage(1, 2, 5, 1, 0, 1, 0);
    stage(5, 0, 6, 1, 0, 1, 0);
    stage(1, 6, 7, 1, 0, 1, 0);
    stage(7, 7, 8, 1, 0, 1, 0);
    // R4: register 0, no write, empty slot
    cur_req = "R4";
    stage(1, 1, 0, 1, 0, 1, 0);
    stage(0, 0, 3, 0, 0, 1, 0);
    stage(3, 3, 4, 1, 0, 1, 0);
    stage(0, 0, 9, 1, 0, 0, 0);
    stage(9, 9, 2, 1, 0, 1, 0);
    // R5 / R6: load-use, two bubbles, replay, then no repeat
    cur_req = "R5 R6";
    stage(1, 1, 9, 1, 1, 1, 0);
    stage(3, 9, 10, 1, 0, 1, 0);
    stage(10, 10, 11, 1, 0, 1, 0);
    stage(2, 2, 12, 1, 0, 1, 0);
    stage(3, 9, 10, 1, 0, 1, 0);
    stage(10, 1, 1, 1, 0, 1, 0);
    // R7 / R9 / R11 / R10: taken branch squashes two, load-use hidden
    cur_req = "R7 R9 R10 R11";
    stage(1, 2, 0, 0, 0, 1, 0);
    stage(1, 1, 12, 1, 1, 1, 1);
    stage(12, 12, 11, 1, 0, 1, 1);
    stage(11, 11, 13, 1, 0, 1, 0);
    stage(13, 2, 14, 1, 0, 1, 0);
    stage(0, 0, 0, 0, 0, 0, 0);
    stage(0, 0, 0, 0, 0, 0, 0);
    // R8: not-taken branch costs nothing
    cur_req = "R8";
    stage(1, 2, 15, 1, 0, 1, 0);
    stage(15, 2, 16, 1, 0, 1, 0);
    stage(16, 15, 17, 1, 0, 1, 0);
    // R9: branch flag ignored while execute holds a bubble
    cur_req = "R9";
    stage(1, 1, 4, 1, 1, 1, 0);
    stage(4, 0, 5, 1, 0, 1, 0);
    stage(0, 0, 5, 1, 0, 1, 1);
    stage(4, 0, 5, 1, 0, 1, 1);
    stage(5, 5, 6, 1, 0, 1, 0);
    // mixed patterns over R3 R4 R5 R7 R10 R11
    cur_req = "R3 R5 R7 R10 R11 mixed";
    for (int i = 0; i < 600; i++)
      stage($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0,
            $urandom_range(0, 5) != 0, $urandom_range(0, 4) == 0);
    done = 1;
    summary();
    $finish;
  end
endmodule